// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects eight interrupt request lines, arbitrates between them and presents a single interrupt line to a processor. Each line has its own mask bit and its own trigger setting, level or edge. A request register captures the lines, a service register records which levels the processor is currently handling, and a mask register blocks individual lines. A resolver compares the highest pending unmasked request against the highest level in service. It raises the interrupt output only when the pending request has strictly higher priority.

Software controls the block through a small register port of four addresses. Address 0 takes commands: read-select, end-of-interrupt, setting the lowest-priority level, and switching automatic rotation on or off. Address 1 holds the mask, address 2 holds the trigger settings, and address 3 holds the vector base. When the processor pulses acknowledge, the winning level moves into service and a vector is returned on the following cycle. The priority order is a ring: after reset level 0 is highest and level 7 is lowest. Software can move the lowest point directly, or let every end-of-interrupt move it to the level just retired.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The trigger register (address 2) has one bit per line, and bit i = 1 selects edge mode for line i. In level mode the request bit follows the line one cycle later. In edge mode a rising edge sets the bit, and the bit stays set when the line falls. Acknowledge of that level clears the bit. A line held high after acknowledge does not set the bit again until it has gone low and risen.
- R2: The mask register (address 1) reads back as written. A request whose mask bit is 1 never raises the interrupt output and never wins acknowledge.
- R3: The interrupt output is high exactly when some unmasked request bit is set and its level ranks strictly above every level in service. An empty service register counts as ranking below everything.
- R4: After reset the ring runs level 0 (highest) to level 7 (lowest), so the lowest-numbered unmasked request wins.
- R5: Acknowledge while the interrupt output is high sets the winner's service bit and clears its request bit in edge mode. On the next cycle the vector output equals {base, level}: base is bits 7:3 of the last write to address 3, and the level fills bits 2:0. Acknowledge while the interrupt output is low changes nothing.
- R6: Command 0x40 (non-specific end-of-interrupt) clears the highest-ranked service bit. Command 0x60|L (specific end-of-interrupt) clears service bit L.
- R7: Command 0x80|L makes L the lowest level. Priority then runs L+1 (highest), L+2, and so on around to L, modulo 8.
- R8: Command 0xC0 turns automatic rotation on and command 0xA0 turns it off. While rotation is on, every end-of-interrupt makes the cleared level the lowest.
- R9: Reads at address 0 return the request register after command 0x00 and the service register after command 0x20. Reads at address 1 return the mask, at address 2 the trigger settings, and at address 3 the base in bits 7:3 with bits 2:0 read as zero.
- R10: After reset the registers hold these values: mask 0x00, trigger 0xFF, base 0, request and service 0, lowest level 7, rotation off, read-select on the request register, interrupt output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| ack | input | 1 | Interrupt acknowledge, one-cycle pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the last accepted acknowledge |

## Verification
A change on a request line reaches the request register at the next rising edge. The interrupt output follows combinationally from the registers, so both are due one edge after the line changes. A register write or command takes effect at the edge where the strobe is sampled, and read data is combinational on the address. Acknowledge updates the service register, the request register and the vector at the edge that samples it. The bench drives every input on the falling edge, so exactly one rising edge separates a stimulus from its sample point, and it samples on the next falling edge. Exhaustive sweeps cover every request pattern against every lowest-level setting and every mask value, with the expected winner computed by walking the ring.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // command opcode, top three bits of a write to address 0
   typedef enum logic [2:0] {
      CMD_SEL_REQ  = 3'b000,
      CMD_SEL_SVC  = 3'b001,
      CMD_EOI_NS   = 3'b010,
      CMD_EOI_SPEC = 3'b011,
      CMD_SET_LOW  = 3'b100,
      CMD_ROT_OFF  = 3'b101,
      CMD_ROT_ON   = 3'b110,
      CMD_NONE     = 3'b111
   } irq_cmd_e;

   localparam logic [1:0] ADR_CMD  = 2'd0;
   localparam logic [1:0] ADR_MASK = 2'd1;
   localparam logic [1:0] ADR_TRIG = 2'd2;
   localparam logic [1:0] ADR_BASE = 2'd3;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] line,
   input  logic [N-1:0] edge_mode,
   input  logic [N-1:0] clr,
   output logic [N-1:0] req
);
   logic [N-1:0] line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= line;
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            req[i] <= 1'b0;
         else if (!edge_mode[i])
            req[i] <= line[i];
         else if (line[i] && !line_q[i])
            req[i] <= 1'b1;
         else if (clr[i])
            req[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_ring_pick.sv
module irq_ring_pick #(
   parameter int LVL_W = 3,
   localparam int N = 1 << LVL_W
) (
   input  logic [N-1:0]     vec,
   input  logic [LVL_W-1:0] lowest,
   output logic             any,
   output logic [LVL_W-1:0] idx
);
   logic [LVL_W-1:0] start;
   logic [LVL_W-1:0] cand;

   assign start = lowest + 1'b1;

   always_comb begin
      any  = 1'b0;
      idx  = '0;
      cand = '0;
      // walk from lowest rank upward; the last hit is the highest rank
      for (int k = N - 1; k >= 0; k--) begin
         cand = start + LVL_W'(k);
         if (vec[cand]) begin
            any = 1'b1;
            idx = cand;
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_pkg::*;
#(
   parameter int LVL_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [(1<<LVL_W)-1:0] irq_in,
   input  logic                 wr_en,
   input  logic [1:0]           addr,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [DATA_W-1:0]    rd_data,
   input  logic                 ack,
   output logic                 int_out,
   output logic [DATA_W-1:0]    vector
);
   localparam int N      = 1 << LVL_W;
   localparam int BASE_W = DATA_W - LVL_W;

   initial begin
      assert (DATA_W >= N) else $error("DATA_W must hold one bit per level");
      assert (DATA_W >= LVL_W + 3) else $error("DATA_W too narrow for commands");
   end

   logic [N-1:0]      irr, isr, imr, trig;
   logic [LVL_W-1:0]  lowest;
   logic              rot_en, rd_isr;
   logic [BASE_W-1:0] base;
   logic [DATA_W-1:0] vec_q;

   logic              pend_any, svc_any;
   logic [LVL_W-1:0]  pend_idx, svc_idx;
   logic              take;
   logic [N-1:0]      take_clr;

   logic              cmd_we;
   irq_cmd_e          op;
   logic [LVL_W-1:0]  op_lvl;
   logic              eoi_do;
   logic [LVL_W-1:0]  eoi_lvl;

   function automatic logic [LVL_W-1:0] rank_of(input logic [LVL_W-1:0] l,
                                                input logic [LVL_W-1:0] low);
      return l - low - 1'b1;
   endfunction

   irq_req_latch #(.N(N)) u_req (
      .clk(clk), .rst_n(rst_n), .line(irq_in), .edge_mode(trig),
      .clr(take_clr), .req(irr)
   );

   irq_ring_pick #(.LVL_W(LVL_W)) u_pend (
      .vec(irr & ~imr), .lowest(lowest), .any(pend_any), .idx(pend_idx)
   );

   irq_ring_pick #(.LVL_W(LVL_W)) u_svc (
      .vec(isr), .lowest(lowest), .any(svc_any), .idx(svc_idx)
   );

   assign int_out  = pend_any &&
                     (!svc_any || (rank_of(pend_idx, lowest) < rank_of(svc_idx, lowest)));
   assign take     = ack && int_out;
   assign take_clr = take ? (N'(1) << pend_idx) : '0;

   assign cmd_we = wr_en && (addr == ADR_CMD);
   assign op     = irq_cmd_e'(wr_data[DATA_W-1 -: 3]);
   assign op_lvl = wr_data[LVL_W-1:0];

   always_comb begin
      eoi_do  = 1'b0;
      eoi_lvl = op_lvl;
      if (cmd_we && op == CMD_EOI_NS && svc_any) begin
         eoi_do  = 1'b1;
         eoi_lvl = svc_idx;
      end else if (cmd_we && op == CMD_EOI_SPEC) begin
         eoi_do  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr    <= '0;
         imr    <= '0;
         trig   <= '1;
         base   <= '0;
         lowest <= '1;
         rot_en <= 1'b0;
         rd_isr <= 1'b0;
         vec_q  <= '0;
      end else begin
         isr <= (isr | take_clr) & ~(eoi_do ? (N'(1) << eoi_lvl) : '0);
         if (take) vec_q <= {base, pend_idx};
         if (wr_en && addr == ADR_MASK) imr  <= wr_data[N-1:0];
         if (wr_en && addr == ADR_TRIG) trig <= wr_data[N-1:0];
         if (wr_en && addr == ADR_BASE) base <= wr_data[DATA_W-1:LVL_W];
         if (cmd_we && op == CMD_SET_LOW)  lowest <= op_lvl;
         else if (eoi_do && rot_en)        lowest <= eoi_lvl;
         if (cmd_we && op == CMD_ROT_ON)  rot_en <= 1'b1;
         if (cmd_we && op == CMD_ROT_OFF) rot_en <= 1'b0;
         if (cmd_we && op == CMD_SEL_REQ) rd_isr <= 1'b0;
         if (cmd_we && op == CMD_SEL_SVC) rd_isr <= 1'b1;
      end
   end

   assign vector = vec_q;

   always_comb begin
      case (addr)
         ADR_CMD:  rd_data = DATA_W'(rd_isr ? isr : irr);
         ADR_MASK: rd_data = DATA_W'(imr);
         ADR_TRIG: rd_data = DATA_W'(trig);
         default:  rd_data = {base, {LVL_W{1'b0}}};
      endcase
   end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int LVL_W  = 3,
   parameter int DATA_W = 8,
   localparam int N = 1 << LVL_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic              int_out,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] vector,
   input logic [N-1:0]      irr,
   input logic [N-1:0]      imr,
   input logic [N-1:0]      isr,
   input logic [LVL_W-1:0]  pend_idx
);
   // R3
   int_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((irr & ~imr) != '0));

   // R5
   ack_sets_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && int_out) |=> isr[$past(pend_idx)]);

   // R5
   vector_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && int_out) |=> (vector[LVL_W-1:0] == $past(pend_idx)));

   // R5
   no_service_without_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && int_out) |=> ((isr & ~$past(isr)) == '0));

   // R2
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1) |=> (imr == $past(wr_data[N-1:0])));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .int_out(int_out), .wr_en(wr_en),
   .addr(addr), .wr_data(wr_data), .vector(vector), .irr(irr), .imr(imr),
   .isr(isr), .pend_idx(pend_idx)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       ack = 1'b0;
   logic       int_out;
   logic [7:0] vector;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0] base_v = 8'hB0;

   always #10 clk = ~clk;   // 50 MHz

   prio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .ack(ack), .int_out(int_out),
      .vector(vector)
   );

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #2;
      d = rd_data;
   endtask

   task automatic pulse_ack();
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic set_irq(input logic [7:0] v);
      @(negedge clk);
      irq_in = v;
      @(negedge clk);
   endtask

   // expected winner: walk the ring from lowest+1
   function automatic int winner(input logic [7:0] pat, input int low);
      for (int k = 0; k < 8; k++) begin
         if (pat[(low + 1 + k) % 8]) return (low + 1 + k) % 8;
      end
      return -1;
   endfunction

   initial begin
      logic [7:0] d;
      logic [7:0] last_vec;
      int w;
      int r7_bad, r2_bad;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 int_out", int_out, 0);
      rd(2'd0, d); chk("R10 request", d, 8'h00);
      rd(2'd1, d); chk("R10 mask", d, 8'h00);
      rd(2'd2, d); chk("R10 trigger", d, 8'hFF);
      rd(2'd3, d); chk("R10 base", d, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 int_out after release", int_out, 0);

      wr(2'd3, base_v);
      rd(2'd3, d); chk("R9 base readback", d, 8'hB0);
      wr(2'd2, 8'h00);          // all level mode
      rd(2'd2, d); chk("R9 trigger readback", d, 8'h00);

      // R4 fixed order sweep over all patterns
      for (int p = 1; p < 256; p++) begin
         set_irq(8'(p));
         chk("R4 int_out", int_out, 1);
         pulse_ack();
         chk("R4 vector", vector, base_v | 8'(winner(8'(p), 7)));
         @(negedge clk); irq_in = '0;
         wr(2'd0, 8'h40);
      end
      rd(2'd0, d); chk("R1 level request cleared", d, 8'h00);

      // R7 every lowest setting against every pattern
      r7_bad = 0;
      for (int l = 0; l < 8; l++) begin
         wr(2'd0, 8'h80 | 8'(l));
         for (int p = 1; p < 256; p++) begin
            set_irq(8'(p));
            pulse_ack();
            w = winner(8'(p), l);
            if (vector != (base_v | 8'(w))) begin
               r7_bad++;
               chk("R7 rotated winner", vector, base_v | 8'(w));
            end
            @(negedge clk); irq_in = '0;
            wr(2'd0, 8'h40);
         end
      end
      chk("R7 sweep mismatches", r7_bad, 0);
      wr(2'd0, 8'h87);

      // R2 mask sweep with all lines high
      r2_bad = 0;
      for (int m = 0; m < 256; m++) begin
         wr(2'd1, 8'(m));
         rd(2'd1, d);
         if (d != 8'(m)) begin r2_bad++; chk("R2 mask readback", d, m); end
         set_irq(8'hFF);
         if (int_out != (m != 255)) begin
            r2_bad++; chk("R2 int with mask", int_out, m != 255);
         end
         if (m != 255) begin
            pulse_ack();
            w = winner(~8'(m), 7);
            if (vector != (base_v | 8'(w))) begin
               r2_bad++; chk("R2 masked winner", vector, base_v | 8'(w));
            end
            wr(2'd0, 8'h40);
         end
         @(negedge clk); irq_in = '0;
         @(negedge clk);
      end
      chk("R2 sweep mismatches", r2_bad, 0);
      wr(2'd1, 8'h00);

      // R3 / R6 nesting and end-of-interrupt
      set_irq(8'h08);
      pulse_ack();
      chk("R5 vector level 3", vector, base_v | 8'd3);
      set_irq(8'h28);
      chk("R3 lower level blocked by service", int_out, 0);
      set_irq(8'h2A);
      chk("R3 higher level raises", int_out, 1);
      pulse_ack();
      chk("R5 vector level 1", vector, base_v | 8'd1);
      wr(2'd0, 8'h20);
      rd(2'd0, d); chk("R9 service read", d, 8'h0A);
      set_irq(8'h00);
      wr(2'd0, 8'h40);
      rd(2'd0, d); chk("R6 non-specific clears top", d, 8'h08);
      wr(2'd0, 8'h63);
      rd(2'd0, d); chk("R6 specific clears named", d, 8'h00);

      // R5 ack with int low is ignored
      last_vec = vector;
      pulse_ack();
      chk("R5 ignored ack vector", vector, last_vec);
      rd(2'd0, d); chk("R5 ignored ack service", d, 8'h00);
      wr(2'd0, 8'h00);

      // R1 level mode follows input
      set_irq(8'h40);
      rd(2'd0, d); chk("R1 level set", d, 8'h40);
      set_irq(8'h00);
      rd(2'd0, d); chk("R1 level follows low", d, 8'h00);

      // R1 edge mode
      wr(2'd2, 8'hFF);
      set_irq(8'h04);
      set_irq(8'h00);
      rd(2'd0, d); chk("R1 edge latched", d, 8'h04);
      pulse_ack();
      chk("R5 edge vector", vector, base_v | 8'd2);
      rd(2'd0, d); chk("R5 edge cleared by ack", d, 8'h00);
      wr(2'd0, 8'h40);
      set_irq(8'h10);
      pulse_ack();
      @(negedge clk); @(negedge clk);
      rd(2'd0, d); chk("R1 held line no rearm", d, 8'h00);
      chk("R1 held line no int", int_out, 0);
      wr(2'd0, 8'h40);
      set_irq(8'h00);
      set_irq(8'h10);
      rd(2'd0, d); chk("R1 rearm after low", d, 8'h10);
      set_irq(8'h00);
      pulse_ack();
      wr(2'd0, 8'h40);
      wr(2'd2, 8'h00);

      // R8 automatic rotation
      wr(2'd0, 8'hC0);
      set_irq(8'hFF);
      for (int i = 0; i < 10; i++) begin
         chk("R8 int_out", int_out, 1);
         pulse_ack();
         chk("R8 rotating vector", vector, base_v | 8'(i % 8));
         wr(2'd0, 8'h40);
      end
      wr(2'd0, 8'hA0);
      pulse_ack();
      chk("R8 after rotation off", vector, base_v | 8'd2);
      wr(2'd0, 8'h40);
      pulse_ack();
      chk("R8 lowest kept when off", vector, base_v | 8'd2);
      wr(2'd0, 8'h40);
      set_irq(8'h00);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule